// File: doc/BRIEF.md
# Predicated Floating-Point Precision Converter

This block is one lane of a vector floating-point unit. It changes the precision of a single element, in either direction, between IEEE half, single and double precision. A 2-bit size field and a 2-bit opcode field together pick one of six conversions. Each call carries the source container, the container the destination held before, an active-lane predicate bit and a flush-to-zero control.

Active lanes are converted with round-to-nearest-even. The result is returned together with the four IEEE exception flags that a conversion can raise. Inactive lanes, and lanes with an encoding outside the six, hand back the old destination unchanged.

Half precision is always treated as the standard IEEE format. Subnormal values going into or coming out of half precision are never flushed. Only the single/double pair obeys the flush-to-zero control. The output is registered, so the answer for a request appears on the next clock edge and then holds until the next request.

Top module: `fpPrecConv`

## Requirements
- R1: With {sizeSel, opSel} as 1000 single→half, 1001 half→single, 1100 double→half, 1101 half→double, 1110 double→single, 1111 single→double, an active lane converts the source element to the selected format.
- R2: outValid rises in the cycle after a cycle with inValid high and is low after a cycle with inValid low. resultBox and the flags hold their last values while inValid is low. After reset, outValid, resultBox and all flags are zero.
- R3: For an inactive lane (laneActive low), or any {sizeSel, opSel} outside the six of R1, resultBox equals oldDest and all four flags are zero.
- R4: The source element is read from the low bits of srcBox. The converted element is written to the low bits of resultBox, and all bits above the element are zero. The single↔half pair uses a 32-bit container, so resultBox[63:32] is zero for those conversions.
- R5: Conversions from or to half precision ignore flushZero. A subnormal half source is converted exactly. A tiny half result is produced as a subnormal, with normal flags.
- R6: For single↔double with flushZero high, a subnormal source becomes a zero of the same sign and raises no flag. A result that is tiny before rounding becomes a zero of the same sign and raises underflow only.
- R7: Narrowing rounds to nearest, with ties to even. Any discarded nonzero bit raises inexact.
- R8: A narrowed value whose rounded magnitude exceeds the largest finite value of the target gives infinity with the source sign, and raises overflow and inexact.
- R9: A result that is tiny before rounding and also inexact raises underflow. A tiny result that is exact raises no flag.
- R10: A signalling NaN raises invalid and is returned quiet. A quiet NaN raises nothing. The payload keeps its most significant bits on narrowing and is zero-extended on widening. The sign is kept.
- R11: Infinities and zeros convert to the same class with the same sign and raise no flag.
- R12: Widening conversions are exact and never raise overflow, underflow or inexact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Request strobe |
| srcBox | input | 64 | Source container |
| sizeSel | input | 2 | Size field of the conversion select |
| opSel | input | 2 | Opcode field of the conversion select |
| laneActive | input | 1 | Predicate bit for this lane |
| oldDest | input | 64 | Previous destination container |
| flushZero | input | 1 | Flush-to-zero control |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| resultBox | output | 64 | Result container |
| flagInvalid | output | 1 | Invalid operation |
| flagOverflow | output | 1 | Overflow |
| flagUnderflow | output | 1 | Underflow |
| flagInexact | output | 1 | Inexact |

## Verification
The only internal state is the single output stage, and every request overwrites it. A wrong decode strobe or a wrong rounding decision therefore shows up on resultBox or the flags in the very cycle that outValid rises for that request. The vectors sit on the boundaries where a slip changes a port value: ties, just-below-minimum-normal values, rounding carries into the exponent, and subnormals with flushZero set on both the half and the single/double paths. A mismatch on any of these is reported one cycle after the request is driven.

// File: rtl/fpcvt_pkg.sv
package fpcvt_pkg;
  localparam int CONT_W = 64;
  localparam int SIG_W  = 53;
  localparam int FRAC_W = SIG_W - 1;

  typedef enum logic [1:0] {
    FMT_HALF   = 2'd0,
    FMT_SINGLE = 2'd1,
    FMT_DOUBLE = 2'd2
  } fmtSel_e;

  typedef struct packed {
    logic    loadOut;
    logic    doConvert;
    fmtSel_e srcFmt;
    fmtSel_e dstFmt;
    logic    flushIn;
    logic    flushOut;
  } ctrlStrobe_t;

  function automatic int fmtFracBits(fmtSel_e f);
    case (f)
      FMT_HALF:   return 10;
      FMT_SINGLE: return 23;
      default:    return 52;
    endcase
  endfunction

  function automatic int fmtExpBits(fmtSel_e f);
    case (f)
      FMT_HALF:   return 5;
      FMT_SINGLE: return 8;
      default:    return 11;
    endcase
  endfunction

  function automatic int fmtBias(fmtSel_e f);
    return (1 << (fmtExpBits(f) - 1)) - 1;
  endfunction

  function automatic int fmtMaxExp(fmtSel_e f);
    return (1 << fmtExpBits(f)) - 1;
  endfunction

  function automatic int leadZeros(logic [FRAC_W-1:0] v);
    int n;
    logic seen;
    n = 0;
    seen = 1'b0;
    for (int i = FRAC_W - 1; i >= 0; i--) begin
      if (!seen && !v[i]) n++;
      if (v[i]) seen = 1'b1;
    end
    return n;
  endfunction
endpackage

// File: rtl/fpcvtCtrl.sv
module fpcvtCtrl
  import fpcvt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        laneActive,
  input  logic [1:0]  sizeSel,
  input  logic [1:0]  opSel,
  input  logic        flushZero,
  output ctrlStrobe_t strobe,
  output logic        outValid
);
  logic    legal;
  fmtSel_e srcFmt;
  fmtSel_e dstFmt;
  logic    pairSingleDouble;

  always_comb begin
    legal  = 1'b1;
    srcFmt = FMT_SINGLE;
    dstFmt = FMT_HALF;
    case ({sizeSel, opSel})
      4'b1000: begin srcFmt = FMT_SINGLE; dstFmt = FMT_HALF;   end
      4'b1001: begin srcFmt = FMT_HALF;   dstFmt = FMT_SINGLE; end
      4'b1100: begin srcFmt = FMT_DOUBLE; dstFmt = FMT_HALF;   end
      4'b1101: begin srcFmt = FMT_HALF;   dstFmt = FMT_DOUBLE; end
      4'b1110: begin srcFmt = FMT_DOUBLE; dstFmt = FMT_SINGLE; end
      4'b1111: begin srcFmt = FMT_SINGLE; dstFmt = FMT_DOUBLE; end
      default: legal = 1'b0;
    endcase
  end

  assign pairSingleDouble = (srcFmt != FMT_HALF) && (dstFmt != FMT_HALF);

  always_comb begin
    strobe.loadOut   = inValid;
    strobe.doConvert = inValid && laneActive && legal;
    strobe.srcFmt    = srcFmt;
    strobe.dstFmt    = dstFmt;
    strobe.flushIn   = flushZero && pairSingleDouble;
    strobe.flushOut  = flushZero && pairSingleDouble;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/fpcvtDatapath.sv
module fpcvtDatapath
  import fpcvt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [CONT_W-1:0] srcBox,
  input  logic [CONT_W-1:0] oldDest,
  output logic [CONT_W-1:0] resultBox,
  output logic [3:0]        flagsOut
);
  // flag vector order: {invalid, overflow, underflow, inexact}
  logic              sgn;
  logic [10:0]       expField;
  logic [FRAC_W-1:0] fracW;
  logic [SIG_W-1:0]  sig;
  int                srcBias, srcMaxE, lz, expUnb;
  logic              expIsMax, expIsZero, isNan, isInf, isZero;

  int                dstFrac, dstExpW, dstBias, dstMaxE, dstEmin, shiftAmt, biased;
  logic              tiny, roundUp, lostBits, ovf;
  logic [63:0]       sig64, remBits, halfPt, kept, rounded, fracMask, fracOut;
  logic [CONT_W-1:0] convResult;
  logic [3:0]        convFlags;

  // Unpack the source into sign, unbiased exponent and normalised significand
  always_comb begin
    sgn      = 1'b0;
    expField = '0;
    fracW    = '0;
    case (strobe.srcFmt)
      FMT_HALF: begin
        sgn = srcBox[15]; expField = {6'b0, srcBox[14:10]}; fracW = {srcBox[9:0], 42'b0};
      end
      FMT_SINGLE: begin
        sgn = srcBox[31]; expField = {3'b0, srcBox[30:23]}; fracW = {srcBox[22:0], 29'b0};
      end
      default: begin
        sgn = srcBox[63]; expField = srcBox[62:52]; fracW = srcBox[51:0];
      end
    endcase
    srcBias   = fmtBias(strobe.srcFmt);
    srcMaxE   = fmtMaxExp(strobe.srcFmt);
    expIsMax  = int'(expField) == srcMaxE;
    expIsZero = expField == '0;
    isNan     = expIsMax && (fracW != '0);
    isInf     = expIsMax && (fracW == '0);
    isZero    = expIsZero && ((fracW == '0) || strobe.flushIn);
    lz        = leadZeros(fracW);
    if (expIsZero) begin
      sig    = {fracW, 1'b0} << lz;
      expUnb = -srcBias - lz;
    end else begin
      sig    = {1'b1, fracW};
      expUnb = int'(expField) - srcBias;
    end
  end

  // Round to nearest even and pack into the destination format
  always_comb begin
    dstFrac  = fmtFracBits(strobe.dstFmt);
    dstExpW  = fmtExpBits(strobe.dstFmt);
    dstBias  = fmtBias(strobe.dstFmt);
    dstMaxE  = fmtMaxExp(strobe.dstFmt);
    dstEmin  = 1 - dstBias;
    tiny     = expUnb < dstEmin;
    shiftAmt = FRAC_W - dstFrac + (tiny ? dstEmin - expUnb : 0);
    if (shiftAmt > 63) shiftAmt = 63;
    sig64    = {11'b0, sig};
    remBits  = sig64 & ((64'd1 << shiftAmt) - 64'd1);
    halfPt   = (shiftAmt == 0) ? 64'd0 : (64'd1 << (shiftAmt - 1));
    kept     = sig64 >> shiftAmt;
    lostBits = remBits != 64'd0;
    roundUp  = (shiftAmt != 0) && ((remBits > halfPt) || ((remBits == halfPt) && kept[0]));
    rounded  = kept + {63'b0, roundUp};
    fracMask = (64'd1 << dstFrac) - 64'd1;
    fracOut  = rounded & fracMask;
    if (tiny) biased = int'((rounded >> dstFrac) & 64'd1);
    else      biased = expUnb + dstBias + int'((rounded >> (dstFrac + 1)) & 64'd1);
    ovf      = !tiny && (biased >= dstMaxE);

    convFlags  = 4'b0000;
    convResult = '0;
    if (isNan) begin
      convResult = (64'(sgn) << (dstExpW + dstFrac)) | (64'(dstMaxE) << dstFrac)
                 | (64'(fracW) >> (FRAC_W - dstFrac)) | (64'd1 << (dstFrac - 1));
      convFlags[3] = !fracW[FRAC_W-1];
    end else if (isInf) begin
      convResult = (64'(sgn) << (dstExpW + dstFrac)) | (64'(dstMaxE) << dstFrac);
    end else if (isZero) begin
      convResult = 64'(sgn) << (dstExpW + dstFrac);
    end else if (tiny && strobe.flushOut) begin
      convResult   = 64'(sgn) << (dstExpW + dstFrac);
      convFlags[1] = 1'b1;
    end else if (ovf) begin
      convResult = (64'(sgn) << (dstExpW + dstFrac)) | (64'(dstMaxE) << dstFrac);
      convFlags  = 4'b0101;
    end else begin
      convResult   = (64'(sgn) << (dstExpW + dstFrac)) | (64'(biased) << dstFrac) | fracOut;
      convFlags[1] = tiny && lostBits;
      convFlags[0] = lostBits;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultBox <= '0;
      flagsOut  <= '0;
    end else if (strobe.loadOut) begin
      resultBox <= strobe.doConvert ? convResult : oldDest;
      flagsOut  <= strobe.doConvert ? convFlags : 4'b0000;
    end
  end
endmodule

// File: rtl/fpPrecConv.sv
module fpPrecConv
  import fpcvt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [CONT_W-1:0] srcBox,
  input  logic [1:0]        sizeSel,
  input  logic [1:0]        opSel,
  input  logic              laneActive,
  input  logic [CONT_W-1:0] oldDest,
  input  logic              flushZero,
  output logic              outValid,
  output logic [CONT_W-1:0] resultBox,
  output logic              flagInvalid,
  output logic              flagOverflow,
  output logic              flagUnderflow,
  output logic              flagInexact
);
  ctrlStrobe_t strobe;
  logic [3:0]  flagsOut;

  fpcvtCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .laneActive(laneActive),
    .sizeSel(sizeSel), .opSel(opSel), .flushZero(flushZero),
    .strobe(strobe), .outValid(outValid)
  );

  fpcvtDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcBox(srcBox),
    .oldDest(oldDest), .resultBox(resultBox), .flagsOut(flagsOut)
  );

  assign {flagInvalid, flagOverflow, flagUnderflow, flagInexact} = flagsOut;
endmodule

// File: rtl/fpcvtChecker.sv
module fpcvtChecker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [1:0]  sizeSel,
  input logic [1:0]  opSel,
  input logic        laneActive,
  input logic [63:0] oldDest,
  input logic        outValid,
  input logic [63:0] resultBox,
  input logic        flagInvalid,
  input logic        flagOverflow,
  input logic        flagUnderflow,
  input logic        flagInexact
);
  logic widenReq;
  assign widenReq = inValid && laneActive &&
                    ({sizeSel, opSel} inside {4'b1001, 4'b1101, 4'b1111});

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(resultBox));
  assert_inactive_pass_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !laneActive) |=> (resultBox == $past(oldDest)) &&
      !flagInvalid && !flagOverflow && !flagUnderflow && !flagInexact);
  assert_short_container_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && laneActive && sizeSel == 2'b10 && !opSel[1]) |=> resultBox[63:32] == 32'h0);
  assert_overflow_inexact_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && flagOverflow) |-> flagInexact);
  assert_widen_exact_R12: assert property (@(posedge clk) disable iff (!rstN)
    widenReq |=> !flagOverflow && !flagUnderflow && !flagInexact);
endmodule

bind fpPrecConv fpcvtChecker u_checker (
  .clk(clk), .rstN(rstN), .inValid(inValid), .sizeSel(sizeSel), .opSel(opSel),
  .laneActive(laneActive), .oldDest(oldDest), .outValid(outValid),
  .resultBox(resultBox), .flagInvalid(flagInvalid), .flagOverflow(flagOverflow),
  .flagUnderflow(flagUnderflow), .flagInexact(flagInexact)
);

// File: tb/fpPrecConv_bench.sv
module fpPrecConv_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] srcBox = '0;
  logic [1:0]  sizeSel = '0;
  logic [1:0]  opSel = '0;
  logic        laneActive = 1'b0;
  logic [63:0] oldDest = '0;
  logic        flushZero = 1'b0;
  logic        outValid;
  logic [63:0] resultBox;
  logic        flagInvalid, flagOverflow, flagUnderflow, flagInexact;

  typedef struct {
    logic [63:0] res;
    logic [3:0]  flg;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 0;
  logic [63:0] lastRes;

  always #5 clk = ~clk;

  fpPrecConv u_fpPrecConv (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcBox(srcBox), .sizeSel(sizeSel),
    .opSel(opSel), .laneActive(laneActive), .oldDest(oldDest), .flushZero(flushZero),
    .outValid(outValid), .resultBox(resultBox), .flagInvalid(flagInvalid),
    .flagOverflow(flagOverflow), .flagUnderflow(flagUnderflow), .flagInexact(flagInexact)
  );

  // flags compared as {invalid, overflow, underflow, inexact}
  task automatic push(input logic [3:0] code, input logic [63:0] src, input logic act,
                      input logic [63:0] old, input logic ftz,
                      input logic [63:0] expRes, input logic [3:0] expFlg, input string tag);
    expItem_t it;
    @(negedge clk);
    {sizeSel, opSel} = code;
    srcBox = src; laneActive = act; oldDest = old; flushZero = ftz; inValid = 1'b1;
    it.res = expRes; it.flg = expFlg; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    nChecks++;
    if (act !== expv) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Monitor: compare every result against the head of the queue
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check("R2 unexpected outValid", 64'd1, 64'd0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check({it.tag, " result"}, resultBox, it.res);
        check({it.tag, " flags"},
              {60'b0, flagInvalid, flagOverflow, flagUnderflow, flagInexact}, {60'b0, it.flg});
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset outValid", {63'b0, outValid}, 64'd0);
    check("R2 reset result", resultBox, 64'd0);
    check("R2 reset flags", {60'b0, flagInvalid, flagOverflow, flagUnderflow, flagInexact}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 basic conversions, R4 container handling
    push(4'b1000, 64'hFFFF_FFFF_3F80_0000, 1, 64'hAAAA_AAAA_AAAA_AAAA, 0, 64'h3C00, 4'b0000, "R1 R4 s2h one");
    push(4'b1001, 64'hFFFF_FFFF_FFFF_3C00, 1, 64'hAAAA_AAAA_AAAA_AAAA, 0, 64'h3F80_0000, 4'b0000, "R1 R4 h2s one");
    push(4'b1100, 64'h3FF0_0000_0000_0000, 1, 64'h5555_5555_5555_5555, 0, 64'h3C00, 4'b0000, "R1 d2h one");
    push(4'b1101, 64'h0000_0000_0000_C000, 1, 64'h0, 0, 64'hC000_0000_0000_0000, 4'b0000, "R1 h2d minus two");
    push(4'b1110, 64'h3FF0_0000_0000_0000, 1, 64'h0, 0, 64'h3F80_0000, 4'b0000, "R1 d2s one");
    push(4'b1111, 64'hAAAA_AAAA_3F80_0000, 1, 64'h0, 0, 64'h3FF0_0000_0000_0000, 4'b0000, "R1 R4 s2d one");
    // R7 rounding
    push(4'b1000, 64'h3F80_1000, 1, 64'h0, 0, 64'h3C00, 4'b0001, "R7 tie to even down");
    push(4'b1000, 64'h3F80_3000, 1, 64'h0, 0, 64'h3C02, 4'b0001, "R7 tie to even up");
    push(4'b1000, 64'h3F80_1001, 1, 64'h0, 0, 64'h3C01, 4'b0001, "R7 above half");
    push(4'b1100, 64'h3FF0_0200_0000_1000, 1, 64'h0, 0, 64'h3C01, 4'b0001, "R7 sticky bit");
    // R8 overflow
    push(4'b1000, 64'h477F_E000, 1, 64'h0, 0, 64'h7BFF, 4'b0000, "R8 max finite");
    push(4'b1000, 64'h477F_F000, 1, 64'h0, 0, 64'h7C00, 4'b0101, "R8 rounds to inf");
    push(4'b1000, 64'hC780_0000, 1, 64'h0, 0, 64'hFC00, 4'b0101, "R8 negative inf");
    push(4'b1110, 64'h7E00_0000_0000_0000, 1, 64'h0, 1, 64'h7F80_0000, 4'b0101, "R8 d2s overflow");
    // R9 underflow
    push(4'b1000, 64'h3380_0000, 1, 64'h0, 1, 64'h0001, 4'b0000, "R9 R5 exact subnormal");
    push(4'b1000, 64'h3300_0000, 1, 64'h0, 0, 64'h0000, 4'b0011, "R9 tie to zero");
    push(4'b1000, 64'h3340_0000, 1, 64'h0, 0, 64'h0001, 4'b0011, "R9 rounds to min sub");
    push(4'b1000, 64'h387F_F000, 1, 64'h0, 0, 64'h0400, 4'b0011, "R9 tiny before rounding");
    push(4'b1110, 64'h37D0_0000_0000_0000, 1, 64'h0, 0, 64'h0008_0000, 4'b0000, "R9 d2s exact subnormal");
    push(4'b1110, 64'h0000_0000_0000_0001, 1, 64'h0, 0, 64'h0, 4'b0011, "R9 d2s lost subnormal");
    // R5 half ignores flush control
    push(4'b1001, 64'h0001, 1, 64'h0, 1, 64'h3380_0000, 4'b0000, "R5 h2s subnormal");
    push(4'b1001, 64'h8200, 1, 64'h0, 1, 64'hB800_0000, 4'b0000, "R5 h2s neg subnormal");
    push(4'b1101, 64'h0001, 1, 64'h0, 1, 64'h3E70_0000_0000_0000, 4'b0000, "R5 h2d subnormal");
    push(4'b1100, 64'h0000_0000_0000_0001, 1, 64'h0, 1, 64'h0, 4'b0011, "R5 d2h no input flush");
    // R6 single/double flush
    push(4'b1111, 64'h8000_0001, 1, 64'h0, 1, 64'h8000_0000_0000_0000, 4'b0000, "R6 input flush");
    push(4'b1110, 64'h0000_0000_0000_0001, 1, 64'h0, 1, 64'h0, 4'b0000, "R6 d2s input flush");
    push(4'b1110, 64'h37D0_0000_0000_0000, 1, 64'h0, 1, 64'h0, 4'b0010, "R6 output flush");
    push(4'b1111, 64'h0000_0001, 1, 64'h0, 0, 64'h36A0_0000_0000_0000, 4'b0000, "R12 s2d subnormal");
    // R10 NaNs
    push(4'b1000, 64'h7FA0_0000, 1, 64'h0, 0, 64'h7F00, 4'b1000, "R10 signalling narrow");
    push(4'b1101, 64'h7E01, 1, 64'h0, 0, 64'h7FF8_0400_0000_0000, 4'b0000, "R10 quiet widen");
    push(4'b1111, 64'hFF80_0001, 1, 64'h0, 0, 64'hFFF8_0000_2000_0000, 4'b1000, "R10 signalling widen");
    // R11 specials
    push(4'b1100, 64'hFFF0_0000_0000_0000, 1, 64'h0, 0, 64'hFC00, 4'b0000, "R11 neg inf");
    push(4'b1000, 64'h8000_0000, 1, 64'h0, 0, 64'h8000, 4'b0000, "R11 neg zero");
    // R3 inactive and unsupported
    push(4'b1111, 64'h7FF0_0000_0000_0001, 0, 64'h0123_4567_89AB_CDEF, 0, 64'h0123_4567_89AB_CDEF, 4'b0000, "R3 inactive lane");
    push(4'b0110, 64'h3F80_0000, 1, 64'hFEDC_BA98_7654_3210, 0, 64'hFEDC_BA98_7654_3210, 4'b0000, "R3 unsupported code");
    lastRes = 64'hFEDC_BA98_7654_3210;

    @(negedge clk);
    inValid = 1'b0;
    srcBox = 64'h3F80_0000; sizeSel = 2'b10; opSel = 2'b00; laneActive = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 idle outValid", {63'b0, outValid}, 64'd0);
    check("R2 idle hold", resultBox, lastRes);
    check("R2 queue drained", 64'(expQ.size()), 64'd0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule